// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table that sits in memory. A single-cycle start strobe supplies the virtual address and the table base. The walker then issues one or two 32-bit word reads, at physical addresses, on a simple request/response memory port. It finishes with a one-cycle done pulse. The pulse carries the physical address, a two-bit cacheable/bufferable attribute, or a fault flag.

First-level entries name a fault, a direct section mapping, or a pointer to a coarse or fine second-level table. Second-level entries name a fault or a large, small or tiny page. The parameter `FINE_EN` chooses whether fine second-level tables are followed or treated as faults. Access permissions, domains, caching of translations and bus errors are handled elsewhere.

Top module: `xlat_walker`

## Requirements
- R1: The first read goes to address {tableBase[31:14], virtAddr[31:20], 2'b00}.
- R2: A first-level entry with bits [1:0] = 0 ends the walk with fault = 1, physAddr = 0 and attrCb = 0, and no second read is issued.
- R3: A first-level entry with bits [1:0] = 2 (section) ends the walk after one read with physAddr = {entry[31:20], virtAddr[19:0]}, attrCb = entry[3:2] and fault = 0.
- R4: A first-level entry with bits [1:0] = 1 (coarse table) triggers a second read at {entry[31:10], virtAddr[19:12], 2'b00}.
- R5: With FINE_EN = 1, a first-level entry with bits [1:0] = 3 (fine table) triggers a second read at {entry[31:12], virtAddr[19:10], 2'b00}.
- R6: With FINE_EN = 0, a first-level entry with bits [1:0] = 3 ends the walk as a fault with zero address and attribute, and no second read is issued.
- R7: A second-level entry with bits [1:0] = 0 ends the walk as a fault with physAddr = 0 and attrCb = 0.
- R8: A second-level entry with bits [1:0] = 1 (large page) gives physAddr = {entry[31:16], virtAddr[15:0]}.
- R9: A second-level entry with bits [1:0] = 2 (small page) gives physAddr = {entry[31:12], virtAddr[11:0]}.
- R10: A second-level entry with bits [1:0] = 3 (tiny page) gives physAddr = {entry[31:10], virtAddr[9:0]}.
- R11: For every page result, attrCb equals second-level entry bits [3:2] and fault = 0.
- R12: memReqValid holds, with memReqAddr unchanged, until memReqReady is seen. Only one read is outstanding. No request is raised while a response is awaited or while the walker is idle.
- R13: busy is high from the cycle after an accepted start through the done cycle. done is high for exactly one cycle. A start while busy is ignored and does not change the result of the walk in progress.
- R14: A synchronous active-low reset returns the walker to idle, with busy, done, fault, memReqValid, physAddr and attrCb all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | Begin a walk (taken only when idle) |
| virtAddr | input | 32 | Virtual address to translate |
| tableBase | input | 32 | First-level table base (low 14 bits ignored) |
| memReqValid | output | 1 | Read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Physical word address of the read |
| memRspValid | input | 1 | Read data valid strobe |
| memRspData | input | 32 | Read data (table entry) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| physAddr | output | 32 | Translated physical address |
| attrCb | output | 2 | Cacheable/bufferable attribute |

## Verification
The assertions check the port protocol on every cycle. These checks cover:
- a request held with a stable address under backpressure;
- no request while a read is outstanding or while idle;
- the single-cycle done pulse inside busy;
- zeroed address and attribute on every fault;
- the cleared state after reset.

Address formation for each entry kind and the resulting slices only show up in the bench's scenarios. The same holds for the fine-table switch, the ignored start during a walk, and reset in mid-walk. There, a behavioural reference model tracks both a fine-enabled and a fine-disabled instance and compares them against the design on every clock.

// File: rtl/xlat_walker_pkg.sv
package xlat_walker_pkg;

  localparam int WORD_W = 32;
  localparam int KIND_W = 2;
  localparam int ATTR_W = 2;

  localparam logic [KIND_W-1:0] KIND_FAULT = 2'd0;
  localparam logic [KIND_W-1:0] KIND_L1_COARSE = 2'd1;
  localparam logic [KIND_W-1:0] KIND_L1_SECTION = 2'd2;
  localparam logic [KIND_W-1:0] KIND_L1_FINE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch virtual address and base, clear results
    logic nextLoad;    // latch second-level entry address
    logic resSection;  // commit section result
    logic resPage;     // commit page result
    logic resFault;    // commit fault result
    logic useL2;       // request address mux selects second-level pointer
  } walkCtl_t;

endpackage

// File: rtl/xlat_walker_dp.sv
module xlat_walker_dp
  import xlat_walker_pkg::*;
#(
  parameter bit FINE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [WORD_W-1:0] virtAddr,
  input  logic [WORD_W-1:0] tableBase,
  input  logic [WORD_W-1:0] memRspData,
  output logic [WORD_W-1:0] memReqAddr,
  output logic [KIND_W-1:0] rspKind,
  output logic [WORD_W-1:0] physAddr,
  output logic [ATTR_W-1:0] attrCb,
  output logic              fault
);

  logic [WORD_W-1:0] vaQ;
  logic [WORD_W-1:0] baseQ;
  logic [WORD_W-1:0] nextPtrQ;
  logic [WORD_W-1:0] paQ;
  logic [ATTR_W-1:0] attrQ;
  logic              faultQ;

  logic [WORD_W-1:0] l1Addr;
  logic [WORD_W-1:0] coarseNext;
  logic [WORD_W-1:0] fineNext;
  logic [WORD_W-1:0] nextPtr;
  logic [WORD_W-1:0] sectionPa;
  logic [WORD_W-1:0] pagePa;

  assign rspKind    = memRspData[KIND_W-1:0];
  assign l1Addr     = {baseQ[31:14], vaQ[31:20], 2'b00};
  assign coarseNext = {memRspData[31:10], vaQ[19:12], 2'b00};
  assign sectionPa  = {memRspData[31:20], vaQ[19:0]};

  generate
    if (FINE_EN) begin : gFine
      assign fineNext = {memRspData[31:12], vaQ[19:10], 2'b00};
    end else begin : gNoFine
      assign fineNext = '0;
    end
  endgenerate

  assign nextPtr = (rspKind == KIND_L1_FINE) ? fineNext : coarseNext;

  always_comb begin
    unique case (rspKind)
      2'd1:    pagePa = {memRspData[31:16], vaQ[15:0]};
      2'd2:    pagePa = {memRspData[31:12], vaQ[11:0]};
      2'd3:    pagePa = {memRspData[31:10], vaQ[9:0]};
      default: pagePa = '0;
    endcase
  end

  assign memReqAddr = ctl.useL2 ? nextPtrQ : l1Addr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ      <= '0;
      baseQ    <= '0;
      nextPtrQ <= '0;
      paQ      <= '0;
      attrQ    <= '0;
      faultQ   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        vaQ    <= virtAddr;
        baseQ  <= tableBase;
        paQ    <= '0;
        attrQ  <= '0;
        faultQ <= 1'b0;
      end
      if (ctl.nextLoad) begin
        nextPtrQ <= nextPtr;
      end
      if (ctl.resSection) begin
        paQ    <= sectionPa;
        attrQ  <= memRspData[3:2];
        faultQ <= 1'b0;
      end
      if (ctl.resPage) begin
        paQ    <= pagePa;
        attrQ  <= memRspData[3:2];
        faultQ <= 1'b0;
      end
      if (ctl.resFault) begin
        paQ    <= '0;
        attrQ  <= '0;
        faultQ <= 1'b1;
      end
    end
  end

  assign physAddr = paQ;
  assign attrCb   = attrQ;
  assign fault    = faultQ;

endmodule

// File: rtl/xlat_walker_ctl.sv
module xlat_walker_ctl
  import xlat_walker_pkg::*;
#(
  parameter bit FINE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              memReqReady,
  input  logic              memRspValid,
  input  logic [KIND_W-1:0] rspKind,
  output walkCtl_t          ctl,
  output logic              memReqValid,
  output logic              busy,
  output logic              done
);

  walkState_t state;
  walkState_t stateNxt;

  always_comb begin
    stateNxt = state;
    ctl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          ctl.capture = 1'b1;
          stateNxt    = ST_L1_REQ;
        end
      end
      ST_L1_REQ: begin
        if (memReqReady) stateNxt = ST_L1_WAIT;
      end
      ST_L1_WAIT: begin
        if (memRspValid) begin
          unique case (rspKind)
            KIND_L1_SECTION: begin
              ctl.resSection = 1'b1;
              stateNxt       = ST_DONE;
            end
            KIND_L1_COARSE: begin
              ctl.nextLoad = 1'b1;
              stateNxt     = ST_L2_REQ;
            end
            KIND_L1_FINE: begin
              if (FINE_EN) begin
                ctl.nextLoad = 1'b1;
                stateNxt     = ST_L2_REQ;
              end else begin
                ctl.resFault = 1'b1;
                stateNxt     = ST_DONE;
              end
            end
            default: begin
              ctl.resFault = 1'b1;
              stateNxt     = ST_DONE;
            end
          endcase
        end
      end
      ST_L2_REQ: begin
        ctl.useL2 = 1'b1;
        if (memReqReady) stateNxt = ST_L2_WAIT;
      end
      ST_L2_WAIT: begin
        if (memRspValid) begin
          if (rspKind == KIND_FAULT) ctl.resFault = 1'b1;
          else                       ctl.resPage  = 1'b1;
          stateNxt = ST_DONE;
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign memReqValid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign busy        = (state != ST_IDLE);
  assign done        = (state == ST_DONE);

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_walker_pkg::*;
#(
  parameter bit FINE_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic [31:0] virtAddr,
  input  logic [31:0] tableBase,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [31:0] physAddr,
  output logic [1:0]  attrCb
);

  walkCtl_t          ctl;
  logic [KIND_W-1:0] rspKind;

  xlat_walker_ctl #(.FINE_EN(FINE_EN)) uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .startPulse  (startPulse),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspKind     (rspKind),
    .ctl         (ctl),
    .memReqValid (memReqValid),
    .busy        (busy),
    .done        (done)
  );

  xlat_walker_dp #(.FINE_EN(FINE_EN)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .virtAddr   (virtAddr),
    .tableBase  (tableBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .rspKind    (rspKind),
    .physAddr   (physAddr),
    .attrCb     (attrCb),
    .fault      (fault)
  );

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memReqAddr,
  input logic        memRspValid,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [31:0] physAddr,
  input logic [1:0]  attrCb
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rstN) outstanding <= 1'b0;
    else if (memReqValid && memReqReady) outstanding <= 1'b1;
    else if (memRspValid) outstanding <= 1'b0;
  end

  // R12: request held with a stable address under backpressure
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R12: no new request while a read is outstanding
  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    outstanding |-> !memReqValid);

  // R12: requests only during a walk
  a_r12_req_in_walk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> busy);

  // R13: done is a single-cycle pulse inside busy
  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r13_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R2 / R7: a fault carries zero address and attribute
  a_r2_fault_zero: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> physAddr == 32'd0 && attrCb == 2'd0);

  // R14: reset clears the walker
  a_r14_reset_clear: assert property (@(posedge clk)
    !rstN |=> !busy && !done && !fault && !memReqValid && physAddr == 32'd0 && attrCb == 2'd0);

endmodule

bind xlat_walker xlat_walker_chk uChk (
  .clk         (clk),
  .rstN        (rstN),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .physAddr    (physAddr),
  .attrCb      (attrCb)
);

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] virtAddr = '0;
  logic [31:0] tableBase = '0;

  // index 0: fine tables followed, index 1: fine tables disabled
  logic        reqValidV [2];
  logic [31:0] reqAddrV  [2];
  logic        busyV     [2];
  logic        doneV     [2];
  logic        faultV    [2];
  logic [31:0] paV       [2];
  logic [1:0]  attrV     [2];
  logic        memReqReady [2];
  logic        memRspValid [2];
  logic [31:0] memRspData  [2];

  xlat_walker #(.FINE_EN(1'b1)) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .virtAddr(virtAddr), .tableBase(tableBase),
    .memReqValid(reqValidV[0]), .memReqReady(memReqReady[0]), .memReqAddr(reqAddrV[0]),
    .memRspValid(memRspValid[0]), .memRspData(memRspData[0]),
    .busy(busyV[0]), .done(doneV[0]), .fault(faultV[0]), .physAddr(paV[0]), .attrCb(attrV[0]));

  xlat_walker #(.FINE_EN(1'b0)) dutNoFine (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .virtAddr(virtAddr), .tableBase(tableBase),
    .memReqValid(reqValidV[1]), .memReqReady(memReqReady[1]), .memReqAddr(reqAddrV[1]),
    .memRspValid(memRspValid[1]), .memRspData(memRspData[1]),
    .busy(busyV[1]), .done(doneV[1]), .fault(faultV[1]), .physAddr(paV[1]), .attrCb(attrV[1]));

  int tests = 0;
  int fails = 0;
  string curTag = "R14";
  bit finished = 1'b0;

  logic [31:0] mem [logic [31:0]];
  int  latency = 0;
  bit  stallMode = 1'b0;

  // memory model state
  bit          inFl  [2];
  int          cnt   [2];
  logic [31:0] mAddr [2];
  logic        nxtRdy [2];
  logic        nxtRsp [2];
  logic [31:0] nxtDat [2];
  int          cyc = 0;

  // reference model state
  int          rPh    [2];
  logic [31:0] rVa    [2];
  logic [31:0] rReq   [2];
  logic [31:0] rPa    [2];
  logic [1:0]  rAttr  [2];
  logic        rFault [2];
  bit          refOn = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  initial begin
    for (int m = 0; m < 2; m++) begin
      memReqReady[m] = 1'b0; memRspValid[m] = 1'b0; memRspData[m] = '0;
      inFl[m] = 0; cnt[m] = 0; mAddr[m] = '0; nxtRdy[m] = 0; nxtRsp[m] = 0; nxtDat[m] = '0;
      rPh[m] = 0; rVa[m] = '0; rReq[m] = '0; rPa[m] = '0; rAttr[m] = '0; rFault[m] = 0;
    end
  end

  // compare, then advance memory model and reference with the inputs seen at the next edge
  always @(negedge clk) begin
    cyc++;
    for (int m = 0; m < 2; m++) begin
      logic [31:0] d;
      if (refOn) begin
        chk({curTag, " busy"},  {31'd0, busyV[m]},  {31'd0, rPh[m] != 0});
        chk({curTag, " done"},  {31'd0, doneV[m]},  {31'd0, rPh[m] == 5});
        chk({curTag, " req"},   {31'd0, reqValidV[m]}, {31'd0, rPh[m] == 1 || rPh[m] == 3});
        if (rPh[m] == 1 || rPh[m] == 3) chk({curTag, " reqAddr"}, reqAddrV[m], rReq[m]);
        chk({curTag, " pa"},    paV[m], rPa[m]);
        chk({curTag, " attr"},  {30'd0, attrV[m]}, {30'd0, rAttr[m]});
        chk({curTag, " fault"}, {31'd0, faultV[m]}, {31'd0, rFault[m]});
      end
      // memory model
      nxtRsp[m] = 1'b0;
      if (!rstN) begin
        inFl[m] = 0;
      end else begin
        if (reqValidV[m] === 1'b1 && memReqReady[m]) begin
          inFl[m] = 1; cnt[m] = latency; mAddr[m] = reqAddrV[m];
        end
        if (inFl[m]) begin
          if (cnt[m] == 0) begin
            nxtRsp[m] = 1'b1; nxtDat[m] = rd(mAddr[m]); inFl[m] = 0;
          end else cnt[m]--;
        end
      end
      nxtRdy[m] = stallMode ? ((cyc % 3) == m) : 1'b1;
      // reference model
      d = memRspData[m];
      if (!rstN) begin
        rPh[m] = 0; rPa[m] = '0; rAttr[m] = '0; rFault[m] = 0; rReq[m] = '0;
      end else begin
        case (rPh[m])
          0: if (startPulse) begin
               rVa[m] = virtAddr; rPa[m] = '0; rAttr[m] = '0; rFault[m] = 0;
               rReq[m] = (tableBase & 32'hFFFF_C000) | ((virtAddr >> 20) << 2);
               rPh[m] = 1;
             end
          1: if (memReqReady[m]) rPh[m] = 2;
          2: if (memRspValid[m]) begin
               if ((d & 3) == 2) begin
                 rPa[m] = (d & 32'hFFF0_0000) | (rVa[m] & 32'h000F_FFFF);
                 rAttr[m] = 2'((d >> 2) & 3); rPh[m] = 5;
               end else if ((d & 3) == 1) begin
                 rReq[m] = (d & 32'hFFFF_FC00) | (((rVa[m] >> 12) & 32'hFF) << 2); rPh[m] = 3;
               end else if ((d & 3) == 3 && m == 0) begin
                 rReq[m] = (d & 32'hFFFF_F000) | (((rVa[m] >> 10) & 32'h3FF) << 2); rPh[m] = 3;
               end else begin
                 rFault[m] = 1; rPh[m] = 5;
               end
             end
          3: if (memReqReady[m]) rPh[m] = 4;
          4: if (memRspValid[m]) begin
               case (d & 3)
                 0: rFault[m] = 1;
                 1: rPa[m] = (d & 32'hFFFF_0000) | (rVa[m] & 32'h0000_FFFF);
                 2: rPa[m] = (d & 32'hFFFF_F000) | (rVa[m] & 32'h0000_0FFF);
                 default: rPa[m] = (d & 32'hFFFF_FC00) | (rVa[m] & 32'h0000_03FF);
               endcase
               if ((d & 3) != 0) rAttr[m] = 2'((d >> 2) & 3);
               rPh[m] = 5;
             end
          default: rPh[m] = 0;
        endcase
        end
      if (!rstN) refOn = 1'b1;
    end
  end

  always @(posedge clk) begin
    #2;
    for (int m = 0; m < 2; m++) begin
      memReqReady[m] = nxtRdy[m];
      memRspValid[m] = nxtRsp[m];
      memRspData[m]  = nxtRsp[m] ? nxtDat[m] : 32'hDEAD_BEE0;
    end
  end

  task automatic pulseStart(input logic [31:0] va, input logic [31:0] tb);
    @(posedge clk); #2;
    startPulse = 1'b1; virtAddr = va; tableBase = tb;
    @(posedge clk); #2;
    startPulse = 1'b0;
  endtask

  logic [31:0] gotPa [2];
  logic [1:0]  gotAt [2];
  logic        gotF  [2];

  task automatic waitBoth();
    bit seen [2];
    seen[0] = 0; seen[1] = 0;
    for (int i = 0; i < 400 && !(seen[0] && seen[1]); i++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++)
        if (doneV[m] === 1'b1 && !seen[m]) begin
          seen[m] = 1; gotPa[m] = paV[m]; gotAt[m] = attrV[m]; gotF[m] = faultV[m];
        end
    end
    for (int m = 0; m < 2; m++)
      if (!seen[m]) chk({curTag, " done seen"}, 32'd0, 32'd1);
  endtask

  task automatic expect1(input int m, input string tag, input logic [31:0] pa,
                         input logic [1:0] at, input logic f);
    chk({tag, " pa"}, gotPa[m], pa);
    chk({tag, " attr"}, {30'd0, gotAt[m]}, {30'd0, at});
    chk({tag, " fault"}, {31'd0, gotF[m]}, {31'd0, f});
  endtask

  localparam logic [31:0] TB = 32'h0001_2345;  // base 0x0001_0000 after clearing low bits

  initial begin
    mem[32'h0001_048C] = 32'hABC0_0C0E;  // section, attr 3
    mem[32'h0001_0010] = 32'h0002_0401;  // coarse table at 0x0002_0400
    mem[32'h0002_040C] = 32'h7654_3006;  // small page, attr 1
    mem[32'h0002_0454] = 32'h1357_0009;  // large page, attr 2
    mem[32'h0001_0020] = 32'h0003_1003;  // fine table at 0x0003_1000
    mem[32'h0003_1324] = 32'h2468_AC0F;  // tiny page, attr 3

    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    curTag = "R14";
    for (int m = 0; m < 2; m++) begin
      chk("R14 reset busy", {31'd0, busyV[m]}, 32'd0);
      chk("R14 reset pa", paV[m], 32'd0);
    end

    curTag = "R3";  // also R1 via request address compare
    pulseStart(32'h1234_5678, TB); waitBoth();
    expect1(0, "R3 section", 32'hABC4_5678, 2'd3, 1'b0);
    expect1(1, "R3 section nofine", 32'hABC4_5678, 2'd3, 1'b0);

    curTag = "R9";  // coarse walk: R4, R11
    pulseStart(32'h0040_3ABC, TB); waitBoth();
    expect1(0, "R9 small R11", 32'h7654_3ABC, 2'd1, 1'b0);
    expect1(1, "R4 coarse nofine", 32'h7654_3ABC, 2'd1, 1'b0);

    curTag = "R8";
    pulseStart(32'h0041_5678, TB); waitBoth();
    expect1(0, "R8 large R11", 32'h1357_5678, 2'd2, 1'b0);

    curTag = "R10";  // fine walk: R5; nofine instance: R6
    pulseStart(32'h0083_27FF, TB); waitBoth();
    expect1(0, "R10 tiny R5", 32'h2468_AFFF, 2'd3, 1'b0);
    expect1(1, "R6 fine disabled", 32'h0, 2'd0, 1'b1);

    curTag = "R2";
    pulseStart(32'h00C0_0000, TB); waitBoth();
    expect1(0, "R2 l1 fault", 32'h0, 2'd0, 1'b1);

    curTag = "R7";
    pulseStart(32'h0042_0000, TB); waitBoth();
    expect1(0, "R7 l2 fault", 32'h0, 2'd0, 1'b1);

    curTag = "R13";
    pulseStart(32'h1234_5678, TB);
    pulseStart(32'h00C0_0000, TB);
    waitBoth();
    expect1(0, "R13 start ignored", 32'hABC4_5678, 2'd3, 1'b0);
    repeat (6) @(negedge clk);
    chk("R13 no extra walk", {31'd0, busyV[0]}, 32'd0);

    curTag = "R12";
    stallMode = 1'b1; latency = 3;
    pulseStart(32'h0083_27FF, TB); waitBoth();
    expect1(0, "R12 stalled tiny", 32'h2468_AFFF, 2'd3, 1'b0);
    pulseStart(32'h0040_3ABC, TB); waitBoth();
    expect1(1, "R12 stalled small", 32'h7654_3ABC, 2'd1, 1'b0);

    curTag = "R14";
    pulseStart(32'h0040_3ABC, TB);
    repeat (2) @(posedge clk);
    #2 rstN = 1'b0;
    @(posedge clk); #2 rstN = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R14 midwalk busy", {31'd0, busyV[m]}, 32'd0);
      chk("R14 midwalk req", {31'd0, reqValidV[m]}, 32'd0);
    end
    stallMode = 1'b0; latency = 0;
    curTag = "R1";
    pulseStart(32'hFFF0_1234, 32'h0001_3FFF); waitBoth();
    expect1(0, "R1 unmapped index", 32'h0, 2'd0, 1'b1);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule